// File: doc/BRIEF.md
# Access Violation Capture Unit

This unit sits beside the access-permission checkers of a bus fabric and keeps a record of the violations they detect. Each event names the offending slave index, the master ID, the domain ID, the direction and the full address. The unit sets a per-slave status bit, and that bit raises the interrupt unless it is masked. Slaves are split into contiguous groups. Each group keeps the details of its first violation and shows a pending bit.

Software reads the pending register and picks a group with a one-hot select value. It then starts a short shift handshake on the sync register. When the handshake completes, the chosen group's record appears in two shared debug registers. Software then ends the handshake and clears the group's pending bit. The per-slave status and mask words are cleared or changed through the same simple register port.

Register word addresses: mask words at 0x00+w, status words at 0x10+w, debug0 at 0x20, debug1 at 0x21, control at 0x30, pending at 0x31, select at 0x32, sync at 0x33. Reads are combinational; a write takes effect at the clock edge where `reg_we` is high.

Top module: `avc_capture`

## Requirements
- R1: After reset the unit is disabled and `irq` is 0. All status words, pending, select, sync and both debug registers read 0. Every implemented mask bit reads 1, and mask bits at or above NUM_SLAVES read 0.
- R2: A control write with bit 31 set enables the unit, and a write with bit 2 set disables it; bit 2 wins if both are set. Control reads bit 31 = enabled. While the unit is disabled, violation events change neither status nor pending.
- R3: Slave i maps to status word i/32 (address 0x10+i/32), bit i%32, and to mask word i/32 (address 0x00+i/32), bit i%32. Bits for indices at or above NUM_SLAVES read 0. Events with such an index are ignored.
- R4: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A new event on the same edge takes priority over the clear.
- R5: `irq` = enabled AND (OR over all status bits whose mask bit is 0).
- R6: Slave i belongs to group i/SLAVES_PER_GROUP, with SLAVES_PER_GROUP = ceil(NUM_SLAVES/NUM_GROUPS) (10 by default). That group's bit g in the pending register (0x31) sets on its first violation and stores the record. Later events to a pending group are dropped, and the stored record is kept.
- R7: Writing 1 to bit g of the pending register clears that group's pending bit. A capture on the same edge takes priority.
- R8: Sync (0x33) reads 0 when idle. A write of 1 while idle starts a transfer and latches the select register. Sync reads 1 until the XFER_CYCLES-th clock edge after the start edge, and reads 3 from then on. A write of 0 returns it to 0 from any state. A write of 1 while busy or done has no effect.
- R9: On completion, debug0 = {4'b0, addr[35:32], read flag (bit 23), write flag (bit 22), domain [21:16], master [15:0]} and debug1 = addr[31:0]. Both come from the record of the lowest set bit of the latched select, and are all zeros if the select was 0. The read flag is the inverse of the write flag.
- R10: The debug registers change only at the completion of a transfer and otherwise hold their value, including after the sync register returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vio_valid | input | 1 | A detected violation is presented this cycle |
| vio_slave | input | SLV_W | Index of the slave that was accessed |
| vio_master | input | 16 | Master ID of the offending access |
| vio_domain | input | 6 | Domain ID of the offending access |
| vio_write | input | 1 | 1 for a write violation, 0 for a read violation |
| vio_addr | input | 36 | Address of the offending access |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Violation interrupt |

## Verification
The main function is first tried with directed events: one on a slave in the upper, partly used status word, and one on an index beyond the implemented range. Together they separate correct word/bit packing from an off-by-one or an unguarded index. A second event aimed at an already pending group, carrying different data, shows whether first-record retention holds or the record is overwritten. Seeded random events over all groups, including out-of-range indices, are then drained group by group through the shift handshake. Every debug field is compared with a bench model, which exposes swapped fields or flags and wrong group selection. Corner cases cover a zero select, a restart while done, events while disabled, and masking, which tell the interrupt gating apart from the status capture.

// File: rtl/avc_pkg.sv
package avc_pkg;

    localparam int ADDR_W   = 36;
    localparam int MASTER_W = 16;
    localparam int DOMAIN_W = 6;

    typedef struct packed {
        logic [MASTER_W-1:0] master;
        logic [DOMAIN_W-1:0] domain;
        logic                is_wr;
        logic                is_rd;
        logic [ADDR_W-1:0]   addr;
    } vio_rec_t;

    typedef enum logic [1:0] {
        SYNC_IDLE = 2'b00,
        SYNC_BUSY = 2'b01,
        SYNC_DONE = 2'b11
    } sync_state_e;

    localparam logic [7:0] A_MASK = 8'h00;
    localparam logic [7:0] A_STAT = 8'h10;
    localparam logic [7:0] A_DBG0 = 8'h20;
    localparam logic [7:0] A_DBG1 = 8'h21;
    localparam logic [7:0] A_CTRL = 8'h30;
    localparam logic [7:0] A_PEND = 8'h31;
    localparam logic [7:0] A_SEL  = 8'h32;
    localparam logic [7:0] A_SYNC = 8'h33;

    function automatic logic [31:0] pack_dbg0(input vio_rec_t r);
        return {4'b0000, r.addr[35:32], r.is_rd, r.is_wr, r.domain, r.master};
    endfunction

endpackage

// File: rtl/avc_slave_bank.sv
module avc_slave_bank #(
    parameter int NUM_SLAVES = 40,
    parameter int SLV_W      = 6,
    parameter int NUM_WORDS  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_vld,
    input  logic [SLV_W-1:0]        set_idx,
    input  logic                    mask_we,
    input  logic                    stat_we,
    input  logic [3:0]              word_sel,
    input  logic [31:0]             wdata,
    output logic [NUM_WORDS*32-1:0] stat_o,
    output logic [NUM_WORDS*32-1:0] mask_o,
    output logic                    irq_any
);
    localparam int TOT = NUM_WORDS * 32;

    typedef struct packed {
        logic [TOT-1:0] stat;
        logic [TOT-1:0] mask;
    } bank_t;

    bank_t q, d;
    logic [TOT-1:0] valid_bits;

    for (genvar i = 0; i < TOT; i++) begin : g_valid
        assign valid_bits[i] = (i < NUM_SLAVES);
    end

    always_comb begin
        d = q;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (mask_we && word_sel == 4'(w))
                d.mask[w*32 +: 32] = wdata & valid_bits[w*32 +: 32];
            if (stat_we && word_sel == 4'(w))
                d.stat[w*32 +: 32] = q.stat[w*32 +: 32] & ~wdata;
        end
        for (int i = 0; i < NUM_SLAVES; i++) begin
            if (set_vld && set_idx == SLV_W'(i))
                d.stat[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.stat <= '0;
            q.mask <= valid_bits;
        end else begin
            q <= d;
        end
    end

    assign stat_o  = q.stat;
    assign mask_o  = q.mask;
    assign irq_any = |(q.stat & ~q.mask);

    AST_UNUSED_STAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (q.stat & ~valid_bits) == '0); // R3
    AST_STAT_SET_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(set_vld) |-> (q.stat != '0)); // R4

endmodule

// File: rtl/avc_group_store.sv
module avc_group_store
    import avc_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int GRP_W      = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cap_vld,
    input  logic [GRP_W-1:0]                cap_grp,
    input  vio_rec_t                        cap_rec,
    input  logic                            clr_we,
    input  logic [NUM_GROUPS-1:0]           clr_bits,
    output logic [NUM_GROUPS-1:0]           pend_o,
    output vio_rec_t [NUM_GROUPS-1:0]       recs_o
);
    typedef struct packed {
        logic [NUM_GROUPS-1:0]     pend;
        vio_rec_t [NUM_GROUPS-1:0] recs;
    } store_t;

    store_t q, d;

    always_comb begin
        d = q;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (clr_we && clr_bits[g])
                d.pend[g] = 1'b0;
            if (cap_vld && cap_grp == GRP_W'(g) && !q.pend[g]) begin
                d.pend[g] = 1'b1;
                d.recs[g] = cap_rec;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend_o = q.pend;
    assign recs_o = q.recs;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        AST_RECORD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            $past(q.pend[g]) |-> $stable(q.recs[g])); // R6
        AST_PEND_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(q.pend[g]) |-> $past(cap_vld && cap_grp == GRP_W'(g))); // R6
    end

endmodule

// File: rtl/avc_shift_ctrl.sv
module avc_shift_ctrl
    import avc_pkg::*;
#(
    parameter int NUM_GROUPS  = 4,
    parameter int XFER_CYCLES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_we,
    input  logic                      sync_we,
    input  logic [31:0]               wdata,
    input  vio_rec_t [NUM_GROUPS-1:0] recs,
    output logic [NUM_GROUPS-1:0]     sel_o,
    output logic [1:0]                sync_o,
    output logic [31:0]               dbg0_o,
    output logic [31:0]               dbg1_o
);
    localparam int CNT_W = $clog2(XFER_CYCLES + 1);

    typedef struct packed {
        sync_state_e           state;
        logic [CNT_W-1:0]      cnt;
        logic [NUM_GROUPS-1:0] sel;
        logic [NUM_GROUPS-1:0] grab;
        logic [31:0]           dbg0;
        logic [31:0]           dbg1;
    } shift_t;

    shift_t   q, d;
    vio_rec_t pick;

    always_comb begin
        pick = '0;
        for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
            if (q.grab[g]) pick = recs[g];
        end
    end

    always_comb begin
        d = q;
        if (sel_we) d.sel = wdata[NUM_GROUPS-1:0];
        case (q.state)
            SYNC_IDLE: begin
                if (sync_we && wdata == 32'd1) begin
                    d.state = SYNC_BUSY;
                    d.cnt   = CNT_W'(XFER_CYCLES - 1);
                    d.grab  = q.sel;
                end
            end
            SYNC_BUSY: begin
                if (q.cnt == '0) begin
                    d.state = SYNC_DONE;
                    d.dbg0  = pack_dbg0(pick);
                    d.dbg1  = pick.addr[31:0];
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            default: ;
        endcase
        if (sync_we && wdata == 32'd0) d.state = SYNC_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= SYNC_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sel_o  = q.sel;
    assign sync_o = q.state;
    assign dbg0_o = q.dbg0;
    assign dbg1_o = q.dbg1;

    AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SYNC_DONE && $past(q.state) != SYNC_DONE)
        |-> $past(q.state) == SYNC_BUSY); // R8
    AST_DBG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(q.state) != SYNC_BUSY |-> ($stable(q.dbg0) && $stable(q.dbg1))); // R10
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        q.dbg0[31:28] == 4'b0000 && !(q.dbg0[23] && q.dbg0[22])); // R9

endmodule

// File: rtl/avc_capture.sv
module avc_capture
    import avc_pkg::*;
#(
    parameter int NUM_SLAVES  = 40,
    parameter int NUM_GROUPS  = 4,
    parameter int XFER_CYCLES = 4,
    parameter int SLV_W       = $clog2(NUM_SLAVES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vio_valid,
    input  logic [SLV_W-1:0]   vio_slave,
    input  logic [15:0]        vio_master,
    input  logic [5:0]         vio_domain,
    input  logic               vio_write,
    input  logic [35:0]        vio_addr,
    input  logic               reg_we,
    input  logic [7:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq
);
    localparam int NUM_WORDS = (NUM_SLAVES + 31) / 32;
    localparam int SPG       = (NUM_SLAVES + NUM_GROUPS - 1) / NUM_GROUPS;
    localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

    logic en_d, en_q;
    logic cap_vld;
    logic [GRP_W-1:0] cap_grp;
    vio_rec_t cap_rec;
    logic [NUM_WORDS*32-1:0] stat_w, mask_w;
    logic irq_any;
    logic [NUM_GROUPS-1:0] pend, sel;
    vio_rec_t [NUM_GROUPS-1:0] recs;
    logic [1:0] sync;
    logic [31:0] dbg0, dbg1;

    always_comb begin
        en_d = en_q;
        if (reg_we && reg_addr == A_CTRL) begin
            if (reg_wdata[31]) en_d = 1'b1;
            if (reg_wdata[2])  en_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_d;
    end

    assign cap_vld = vio_valid && en_q && (vio_slave < SLV_W'(NUM_SLAVES));
    assign cap_grp = GRP_W'(vio_slave / SLV_W'(SPG));
    assign cap_rec = '{master: vio_master, domain: vio_domain, is_wr: vio_write,
                       is_rd: !vio_write, addr: vio_addr};

    avc_slave_bank #(.NUM_SLAVES(NUM_SLAVES), .SLV_W(SLV_W), .NUM_WORDS(NUM_WORDS)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .set_vld(cap_vld), .set_idx(vio_slave),
        .mask_we(reg_we && reg_addr[7:4] == A_MASK[7:4]),
        .stat_we(reg_we && reg_addr[7:4] == A_STAT[7:4]),
        .word_sel(reg_addr[3:0]), .wdata(reg_wdata),
        .stat_o(stat_w), .mask_o(mask_w), .irq_any(irq_any)
    );

    avc_group_store #(.NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .cap_vld(cap_vld), .cap_grp(cap_grp), .cap_rec(cap_rec),
        .clr_we(reg_we && reg_addr == A_PEND), .clr_bits(reg_wdata[NUM_GROUPS-1:0]),
        .pend_o(pend), .recs_o(recs)
    );

    avc_shift_ctrl #(.NUM_GROUPS(NUM_GROUPS), .XFER_CYCLES(XFER_CYCLES)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .sel_we(reg_we && reg_addr == A_SEL), .sync_we(reg_we && reg_addr == A_SYNC),
        .wdata(reg_wdata), .recs(recs),
        .sel_o(sel), .sync_o(sync), .dbg0_o(dbg0), .dbg1_o(dbg1)
    );

    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (reg_addr == A_MASK + 8'(w)) reg_rdata = mask_w[w*32 +: 32];
            if (reg_addr == A_STAT + 8'(w)) reg_rdata = stat_w[w*32 +: 32];
        end
        case (reg_addr)
            A_DBG0:  reg_rdata = dbg0;
            A_DBG1:  reg_rdata = dbg1;
            A_CTRL:  reg_rdata = {en_q, 31'b0};
            A_PEND:  reg_rdata = 32'(pend);
            A_SEL:   reg_rdata = 32'(sel);
            A_SYNC:  reg_rdata = 32'(sync);
            default: ;
        endcase
    end

    assign irq = en_q && irq_any;

    AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !irq); // R5
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_w != '0)); // R5
    AST_NO_CAPTURE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(en_q) && $past(pend) == '0) |-> pend == '0); // R2

endmodule

// File: tb/avc_capture_bench.sv
module avc_capture_bench;
    localparam int PERIOD = 10;
    localparam int NS     = 40;
    localparam int NG     = 4;
    localparam int SPG    = 10;
    localparam int XFER   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vio_valid = 1'b0;
    logic [5:0]  vio_slave = '0;
    logic [15:0] vio_master = '0;
    logic [5:0]  vio_domain = '0;
    logic        vio_write = 1'b0;
    logic [35:0] vio_addr = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [63:0] m_stat = '0;
    logic [63:0] m_mask = '0;
    logic [NG-1:0] m_pend = '0;
    bit m_en = 0;
    logic [15:0] m_master [NG];
    logic [5:0]  m_domain [NG];
    logic        m_wr     [NG];
    logic [35:0] m_addr   [NG];

    avc_capture u_avc_capture (
        .clk(clk), .rst_n(rst_n), .vio_valid(vio_valid), .vio_slave(vio_slave),
        .vio_master(vio_master), .vio_domain(vio_domain), .vio_write(vio_write),
        .vio_addr(vio_addr), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [31:0] exp_dbg0(input int g);
        return {4'b0, m_addr[g][35:32], !m_wr[g], m_wr[g], m_domain[g], m_master[g]};
    endfunction

    function automatic logic exp_irq();
        return m_en && ((m_stat & ~m_mask) != '0);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] dat);
        reg_we = 1'b1; reg_addr = a; reg_wdata = dat;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] dat);
        reg_addr = a; #1; dat = reg_rdata;
    endtask

    task automatic event_in(input int s, input logic [15:0] mst, input logic [5:0] dom,
                            input logic w, input logic [35:0] ad);
        vio_valid = 1'b1; vio_slave = 6'(s); vio_master = mst; vio_domain = dom;
        vio_write = w; vio_addr = ad;
        @(posedge clk); @(negedge clk);
        vio_valid = 1'b0;
        if (m_en && s < NS) begin
            m_stat[s] = 1'b1;
            if (!m_pend[s/SPG]) begin
                m_pend[s/SPG] = 1'b1;
                m_master[s/SPG] = mst; m_domain[s/SPG] = dom;
                m_wr[s/SPG] = w; m_addr[s/SPG] = ad;
            end
        end
    endtask

    task automatic check_words(input string req);
        logic [31:0] v;
        for (int w = 0; w < 2; w++) begin
            rd(8'h10 + 8'(w), v); chk(req, "status word", v, m_stat[w*32 +: 32]);
        end
        rd(8'h31, v); chk(req, "pending", v, 32'(m_pend));
        #1; chk("R5", "irq", 32'(irq), 32'(exp_irq()));
    endtask

    task automatic drain(input int g);
        logic [31:0] v;
        wr(8'h32, 32'(1) << g);
        wr(8'h33, 32'd1);
        rd(8'h33, v); chk("R8", "sync busy first", v, 32'd1);
        for (int k = 1; k < XFER; k++) begin
            @(negedge clk); rd(8'h33, v); chk("R8", "sync still busy", v, 32'd1);
        end
        @(negedge clk); rd(8'h33, v); chk("R8", "sync done", v, 32'd3);
        rd(8'h20, v); chk("R9", "debug0", v, exp_dbg0(g));
        rd(8'h21, v); chk("R9", "debug1", v, m_addr[g][31:0]);
        wr(8'h33, 32'd0);
        rd(8'h33, v); chk("R8", "sync idle after 0", v, 32'd0);
        rd(8'h21, v); chk("R10", "debug1 held", v, m_addr[g][31:0]);
        wr(8'h31, 32'(1) << g);
        m_pend[g] = 1'b0;
        rd(8'h31, v); chk("R7", "pending cleared", v, 32'(m_pend));
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        m_mask = 64'h0000_00FF_FFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        #1; chk("R1", "irq", 32'(irq), 32'd0);
        rd(8'h00, v); chk("R1", "mask word0", v, 32'hFFFF_FFFF);
        rd(8'h01, v); chk("R1", "mask word1", v, 32'h0000_00FF);
        rd(8'h10, v); chk("R1", "status word0", v, 32'd0);
        rd(8'h31, v); chk("R1", "pending", v, 32'd0);
        rd(8'h33, v); chk("R1", "sync", v, 32'd0);
        rd(8'h20, v); chk("R1", "debug0", v, 32'd0);
        rd(8'h30, v); chk("R1", "control", v, 32'd0);

        // R2 events ignored while disabled
        event_in(5, 16'h1111, 6'h01, 1'b1, 36'h1_0000_0005);
        check_words("R2");

        wr(8'h30, 32'h8000_0000); m_en = 1;
        rd(8'h30, v); chk("R2", "enabled", v, 32'h8000_0000);
        wr(8'h00, 32'd0); wr(8'h01, 32'd0); m_mask = '0;

        // R3 packing in partial word, out-of-range index ignored
        event_in(33, 16'hBEEF, 6'h2A, 1'b1, 36'hA_1234_5678);
        rd(8'h11, v); chk("R3", "slave 33 word1 bit1", v, 32'h2);
        event_in(45, 16'h0BAD, 6'h3F, 1'b0, 36'h5_0000_0000);
        check_words("R3");

        // R5 masking
        wr(8'h01, 32'h2); m_mask[33] = 1'b1;
        #1; chk("R5", "irq masked", 32'(irq), 32'd0);
        wr(8'h01, 32'h0); m_mask[33] = 1'b0;
        #1; chk("R5", "irq unmasked", 32'(irq), 32'd1);

        // R6 second event to pending group 3 dropped
        event_in(35, 16'h2222, 6'h05, 1'b0, 36'h3_3333_3333);
        check_words("R6");
        drain(3);

        // R9 zero select gives zeros; R8 restart while done ignored
        wr(8'h32, 32'd0); wr(8'h33, 32'd1);
        repeat (XFER) @(negedge clk);
        wr(8'h33, 32'd1);
        rd(8'h33, v); chk("R8", "restart while done ignored", v, 32'd3);
        rd(8'h20, v); chk("R9", "zero select debug0", v, 32'd0);
        wr(8'h33, 32'd0);

        // random events then drain every pending group
        for (int n = 0; n < 40; n++) begin
            event_in(int'($urandom % 48), 16'($urandom), 6'($urandom), 1'($urandom),
                     {4'($urandom), $urandom});
        end
        check_words("R6");
        for (int g = 0; g < NG; g++) if (m_pend[g]) drain(g);
        check_words("R7");

        // R4 write-one-to-clear of status, event wins over clear
        wr(8'h10, 32'h0000_00F0); m_stat[7:4] = '0;
        check_words("R4");
        vio_valid = 1'b1; vio_slave = 6'd2; reg_we = 1'b1; reg_addr = 8'h10;
        reg_wdata = 32'h4;
        @(posedge clk); @(negedge clk);
        vio_valid = 1'b0; reg_we = 1'b0;
        m_stat[2] = 1'b1;
        if (!m_pend[0]) begin
            m_pend[0] = 1'b1; m_master[0] = vio_master; m_domain[0] = vio_domain;
            m_wr[0] = vio_write; m_addr[0] = vio_addr;
        end
        check_words("R4");
        wr(8'h10, 32'hFFFF_FFFF); wr(8'h11, 32'hFFFF_FFFF); m_stat = '0;
        check_words("R4");

        // R2 stop, with bit 2 winning over bit 31
        event_in(12, 16'h4444, 6'h04, 1'b1, 36'h0_0000_1000);
        wr(8'h30, 32'h8000_0004); m_en = 0;
        rd(8'h30, v); chk("R2", "stop wins", v, 32'd0);
        #1; chk("R2", "irq off when stopped", 32'(irq), 32'd0);
        event_in(3, 16'h5555, 6'h05, 1'b1, 36'h0);
        check_words("R2");

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule